// File: doc/BRIEF.md
# Automatic Modem Handshake Flow Controller

This block automates modem-style hardware handshaking beside a UART. On the receive side it watches the fill level of the receive FIFO and drives an active-low request output. The output goes high (stop) once the level climbs to an upper threshold, and goes low (go) again once the level drains to a lower threshold. Between the two thresholds it keeps its previous state, which gives hysteresis and avoids chatter on the line.

On the transmit side it synchronizes the remote side's active-low clear input and produces a transmit-enable for the local transmitter. The enable only changes while no frame is in progress, so a frame that has started is always sent whole. Two configuration fields decide whether the automatic mode is on and which of two pin pairs carries it: the request-to-send/clear-to-send pair or the data-terminal-ready/data-set-ready pair. When the automatic mode is off, both output pins follow software-driven levels and both input pins are only synchronized and reported.

Top module: `hfc_ctrl`

## Requirements
- R1: With automatic mode on and `thr_lo_i < thr_hi_i`, a receive level at or above `thr_hi_i` drives the selected request pin high one clock edge after the level is applied.
- R2: With automatic mode on and `thr_lo_i < thr_hi_i`, a receive level at or below `thr_lo_i` drives the selected request pin low one clock edge after the level is applied.
- R3: A receive level strictly between the two thresholds leaves the selected request pin at its previous value.
- R4: When `thr_lo_i >= thr_hi_i`, the selected request pin is driven low one clock edge later, whatever the level.
- R5: With automatic mode on and no frame in progress, `tx_en_o` goes low on the third rising clock edge after the selected clear input goes high, and goes high on the third edge after it returns low; it is unchanged after the second edge.
- R6: While `frame_busy_i` is high in automatic mode, `tx_en_o` does not change; a pending suspend or restart takes effect on the first edge after `frame_busy_i` falls.
- R7: Automatic mode is on when `flow_mode_i == 3'b001`. If `pin_mode_i == 3'b010` the handshake uses `dtr_n_o` and `dsr_n_i`; for any other `pin_mode_i` it uses `rts_n_o` and `cts_n_i`. The unselected output pin follows its software level and the unselected input has no effect on `tx_en_o`.
- R8: When `flow_mode_i != 3'b001`, `rts_n_o` equals `rts_lvl_i`, `dtr_n_o` equals `dtr_lvl_i` in the same cycle, and `tx_en_o` is high from the first edge onward regardless of both input pins.
- R9: During reset the request state is go (pin low in automatic mode), `tx_en_o` is low and both synchronized inputs read high.
- R10: `cts_n_sync_o` and `dsr_n_sync_o` present their pins through a two-flop synchronizer, changing on the second rising edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flow_mode_i | input | 3 | Flow-control field; 3'b001 turns automatic hardware handshaking on |
| pin_mode_i | input | 3 | Pin-function field; 3'b010 selects the DTR/DSR pair |
| rx_level_i | input | LVL_W | Current receive FIFO fill level |
| thr_hi_i | input | LVL_W | Upper (stop) threshold |
| thr_lo_i | input | LVL_W | Lower (go) threshold |
| frame_busy_i | input | 1 | High while the transmitter is sending a frame |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| rts_lvl_i | input | 1 | Software level for the RTS pin when it is not in automatic use |
| dtr_lvl_i | input | 1 | Software level for the DTR pin when it is not in automatic use |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| dtr_n_o | output | 1 | Data-terminal-ready pin, active low |
| tx_en_o | output | 1 | Transmit enable for the UART transmitter |
| cts_n_sync_o | output | 1 | Synchronized clear-to-send level |
| dsr_n_sync_o | output | 1 | Synchronized data-set-ready level |

## Verification
The hardest situation to reach from the ports is the hold region of the hysteresis, because the pin value there depends on the path the level took and on whether the thresholds were ever in an illegal order. The bench sweeps every pair of upper and lower thresholds in a 4-bit level configuration, ramping the level up and back down for each pair and carrying the model state across pair changes, so every entry into the hold region from above, from below and from an illegal configuration is covered. The frame-boundary hold is reached by raising the clear input while a frame is in progress and keeping the frame open well past the synchronizer delay.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

  // Which pin pair carries the automatic handshake
  typedef enum logic {
    PAIR_RTS_CTS = 1'b0,
    PAIR_DTR_DSR = 1'b1
  } hfc_pair_e;

  // Field encodings decoded by this block
  localparam logic [2:0] FLOW_AUTO_HW = 3'b001;
  localparam logic [2:0] PIN_DTR_SEL  = 3'b010;

endpackage

// File: rtl/hfc_sync.sv
module hfc_sync #(
  parameter int   WIDTH   = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= {WIDTH{RST_VAL}};
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/hfc_hyst.sv
module hfc_hyst #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thr_hi_i,
  input  logic [LVL_W-1:0] thr_lo_i,
  output logic             stop_o
);

  logic cfg_ok;
  logic at_high;
  logic at_low;
  logic stop_d;
  logic stop_q;

  assign cfg_ok  = (thr_lo_i < thr_hi_i);
  assign at_high = (level_i >= thr_hi_i);
  assign at_low  = (level_i <= thr_lo_i);

  // Next-state: illegal thresholds force go, otherwise hysteresis
  always_comb begin
    stop_d = stop_q;
    if (!cfg_ok) begin
      stop_d = 1'b0;
    end else if (at_high) begin
      stop_d = 1'b1;
    end else if (at_low) begin
      stop_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
    end else begin
      stop_q <= stop_d;
    end
  end

  assign stop_o = stop_q;

  AST_STOP_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ok && level_i >= thr_hi_i) |=> stop_q); // R1
  AST_GO_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ok && level_i <= thr_lo_i) |=> !stop_q); // R2
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ok && level_i > thr_lo_i && level_i < thr_hi_i) |=> $stable(stop_q)); // R3
  AST_BAD_CFG_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_lo_i >= thr_hi_i) |=> !stop_q); // R4

endmodule

// File: rtl/hfc_txgate.sv
module hfc_txgate (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_on_i,
  input  logic halt_i,
  input  logic busy_i,
  output logic tx_en_o
);

  logic upd_en;
  logic tx_en_d;
  logic tx_en_q;

  // Update only at a frame boundary while automatic mode is on
  always_comb begin
    upd_en  = !hw_on_i || !busy_i;
    tx_en_d = !hw_on_i || !halt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
    end else if (upd_en) begin
      tx_en_q <= tx_en_d;
    end
  end

  assign tx_en_o = tx_en_q;

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_on_i && busy_i) |=> $stable(tx_en_q)); // R6
  AST_BYPASS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_on_i |=> tx_en_q); // R8
  AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_on_i && !busy_i) |=> (tx_en_q == !$past(halt_i))); // R5

endmodule

// File: rtl/hfc_ctrl.sv
module hfc_ctrl
  import hfc_pkg::*;
#(
  parameter int LVL_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       flow_mode_i,
  input  logic [2:0]       pin_mode_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] thr_hi_i,
  input  logic [LVL_W-1:0] thr_lo_i,
  input  logic             frame_busy_i,
  input  logic             cts_n_i,
  input  logic             dsr_n_i,
  input  logic             rts_lvl_i,
  input  logic             dtr_lvl_i,
  output logic             rts_n_o,
  output logic             dtr_n_o,
  output logic             tx_en_o,
  output logic             cts_n_sync_o,
  output logic             dsr_n_sync_o
);

  localparam int IN_W = 2;

  logic [IN_W-1:0] pins_raw;
  logic [IN_W-1:0] pins_sync;
  logic            hw_on;
  hfc_pair_e       pair_sel;
  logic            halt_req;
  logic            stop_req;

  assign pins_raw = {dsr_n_i, cts_n_i};

  hfc_sync #(
    .WIDTH   (IN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_raw),
    .q_o   (pins_sync)
  );

  assign cts_n_sync_o = pins_sync[0];
  assign dsr_n_sync_o = pins_sync[1];

  // Mode decode
  always_comb begin
    hw_on    = (flow_mode_i == FLOW_AUTO_HW);
    pair_sel = (pin_mode_i == PIN_DTR_SEL) ? PAIR_DTR_DSR : PAIR_RTS_CTS;
    halt_req = (pair_sel == PAIR_DTR_DSR) ? pins_sync[1] : pins_sync[0];
  end

  hfc_hyst #(
    .LVL_W (LVL_W)
  ) u_hyst (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (rx_level_i),
    .thr_hi_i (thr_hi_i),
    .thr_lo_i (thr_lo_i),
    .stop_o   (stop_req)
  );

  hfc_txgate u_txgate (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_on_i (hw_on),
    .halt_i  (halt_req),
    .busy_i  (frame_busy_i),
    .tx_en_o (tx_en_o)
  );

  // Pin steering
  always_comb begin
    rts_n_o = rts_lvl_i;
    dtr_n_o = dtr_lvl_i;
    if (hw_on) begin
      if (pair_sel == PAIR_DTR_DSR) begin
        dtr_n_o = stop_req;
      end else begin
        rts_n_o = stop_req;
      end
    end
  end

  AST_PLAIN_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_on |-> (rts_n_o == rts_lvl_i && dtr_n_o == dtr_lvl_i)); // R8
  AST_SPARE_PIN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_on && pin_mode_i == PIN_DTR_SEL) |-> (rts_n_o == rts_lvl_i)); // R7

endmodule

// File: tb/hfc_ctrl_tb_top.sv
`timescale 1ns/1ps
module hfc_ctrl_tb_top;

  localparam int LW = 4;
  localparam int NL = 1 << LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    flow_mode, pin_mode;
  logic [LW-1:0] lvl, hi, lo;
  logic          busy, cts_n, dsr_n, rts_lvl, dtr_lvl;
  logic          rts_n, dtr_n, tx_en, cts_s, dsr_s;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic exp_stop;

  always #4 clk = ~clk;

  hfc_ctrl #(.LVL_W(LW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .flow_mode_i(flow_mode), .pin_mode_i(pin_mode),
    .rx_level_i(lvl), .thr_hi_i(hi), .thr_lo_i(lo), .frame_busy_i(busy),
    .cts_n_i(cts_n), .dsr_n_i(dsr_n), .rts_lvl_i(rts_lvl), .dtr_lvl_i(dtr_lvl),
    .rts_n_o(rts_n), .dtr_n_o(dtr_n), .tx_en_o(tx_en),
    .cts_n_sync_o(cts_s), .dsr_n_sync_o(dsr_s));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Apply level/thresholds, model the hysteresis, check after one edge
  task automatic lvl_step(input int h, input int l, input int v, input bit dtr_pair);
    string tag;
    hi = LW'(h); lo = LW'(l); lvl = LW'(v);
    if (l >= h) begin exp_stop = 1'b0; tag = "R4"; end
    else if (v >= h) begin exp_stop = 1'b1; tag = "R1"; end
    else if (v <= l) begin exp_stop = 1'b0; tag = "R2"; end
    else tag = "R3";
    @(negedge clk);
    chk(tag, dtr_pair ? dtr_n : rts_n, exp_stop);
  endtask

  // Drive the selected clear input and check the three-edge latency
  task automatic clr_step(input bit use_dsr, input logic val, input logic old_en);
    if (use_dsr) dsr_n = val; else cts_n = val;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R5 pre", tx_en, old_en);
    chk("R10", use_dsr ? dsr_s : cts_s, val);
    @(negedge clk);
    chk("R5", tx_en, ~val);
  endtask

  initial begin
    rst_n = 1'b0; flow_mode = 3'b001; pin_mode = 3'b000;
    lvl = '0; hi = 4'd12; lo = 4'd4; busy = 1'b0;
    cts_n = 1'b0; dsr_n = 1'b0; rts_lvl = 1'b1; dtr_lvl = 1'b1;
    exp_stop = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 rts", rts_n, 1'b0);
    chk("R9 txen", tx_en, 1'b0);
    chk("R9 sync", cts_s, 1'b1);
    chk("R9 sync", dsr_s, 1'b1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 start", tx_en, 1'b1);

    // Exhaustive threshold sweep, RTS/CTS pair
    for (int h = 0; h < NL; h++)
      for (int l = 0; l < NL; l++)
        for (int s = 0; s < 2*NL; s++)
          lvl_step(h, l, (s < NL) ? s : (2*NL - 1 - s), 1'b0);
    chk("R7 dtr spare", dtr_n, dtr_lvl);

    // Transmit gating via CTS
    clr_step(1'b0, 1'b1, 1'b1);
    clr_step(1'b0, 1'b0, 1'b0);

    // Frame boundary hold
    busy = 1'b1; cts_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R6 hold", tx_en, 1'b1);
    busy = 1'b0;
    @(negedge clk);
    chk("R6 release", tx_en, 1'b0);
    busy = 1'b1; cts_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 hold", tx_en, 1'b0);
    busy = 1'b0;
    @(negedge clk);
    chk("R6 release", tx_en, 1'b1);

    // DTR/DSR pair selection
    pin_mode = 3'b010;
    rts_lvl = 1'b0;
    #1 chk("R7 rts spare", rts_n, 1'b0);
    rts_lvl = 1'b1;
    #1 chk("R7 rts spare", rts_n, 1'b1);
    for (int v = 0; v < NL; v++) lvl_step(10, 3, v, 1'b1);
    for (int v = NL-1; v >= 0; v--) lvl_step(10, 3, v, 1'b1);
    cts_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 cts ignored", tx_en, 1'b1);
    cts_n = 1'b0;
    clr_step(1'b1, 1'b1, 1'b1);
    clr_step(1'b1, 1'b0, 1'b0);
    pin_mode = 3'b011;
    dsr_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 dsr ignored", tx_en, 1'b1);
    dsr_n = 1'b0;

    // Automatic mode off: plain pins
    for (int m = 0; m < 8; m++) begin
      if (m == 1) continue;
      flow_mode = 3'(m);
      cts_n = 1'b1; dsr_n = 1'b1; lvl = 4'd15; hi = 4'd8; lo = 4'd2;
      for (int k = 0; k < 4; k++) begin
        rts_lvl = k[0]; dtr_lvl = k[1];
        #1;
        chk("R8 rts", rts_n, k[0]);
        chk("R8 dtr", dtr_n, k[1]);
      end
      busy = 1'b1;
      repeat (4) @(negedge clk);
      chk("R8 txen", tx_en, 1'b1);
      busy = 1'b0;
      chk("R10", cts_s, 1'b1);
      cts_n = 1'b0; dsr_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10", dsr_s, 1'b0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule